// File: doc/BRIEF.md
# Bus Error Capture and Report Unit

This unit sits beside a bus master and watches for transactions that fail. Reporting must be enabled. When an error strobe then arrives, the unit freezes a snapshot of the failing transfer: its address, its data, its byte enables and its bus command. It also records two flags:
- whether a posted-write retry budget ran out;
- whether the failure came from a master abort.

The unit then raises a pending flag, and that flag drives an interrupt.

Software reads three registers through a simple select/write port: one control/status word, the captured address and the captured data. After handling the event, software writes a one to the pending bit. That write clears the flag and re-arms capture. Until the clearing write arrives, the first error is kept and later errors cannot overwrite it.

Top module: `bus_err_capture`

## Requirements
- R1: After reset every register reads zero and `err_pend_o` is 0.
- R2: With the enable bit set and no error pending, an `err_i` pulse takes effect one clock later. The address register then reads `addr_i` and the data register reads `data_i`. In the status word, bits 31:28 read `be_i`, bits 27:24 read `cmd_i`, bit 10 reads `rty_exp_i`, bit 9 reads `mabort_i` and bit 8 reads 1.
- R3: While the enable bit is 0, `err_i` captures nothing: all captured fields and bit 8 keep their values.
- R4: While bit 8 is 1, further `err_i` pulses leave the address, data, bits 31:24, bit 10 and bit 9 unchanged.
- R5: Writing the status word with bit 8 = 1 clears bit 8 on the next clock and re-arms capture. Bits 31:24, 10 and 9 keep their captured values.
- R6: Writing the status word with bit 8 = 0 leaves bit 8 unchanged. Written values in bits 31:24, 10, 9 and the reserved bits are ignored.
- R7: Bit 0 of the status word is the enable. It takes the written value and reads back.
- R8: `err_pend_o` always equals bit 8 of the status word.
- R9: The register select decodes as follows: 0 is the status word, 1 is the captured address, 2 is the captured data, and 3 reads zero. Writes with select 1, 2 or 3 change nothing.
- R10: An error that arrives in the same cycle as a clearing write is dropped: bit 8 ends at 0 and the captured address is unchanged. The next error after that is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | 1 | Failed-transaction strobe |
| rty_exp_i | input | 1 | Retry budget exhausted on posted write, qualified by err_i |
| mabort_i | input | 1 | Failure source was a master abort, qualified by err_i |
| addr_i | input | 32 | Address of the current transfer |
| data_i | input | 32 | Data of the current transfer |
| be_i | input | 4 | Byte enables of the current transfer |
| cmd_i | input | 4 | Bus command of the current transfer |
| reg_sel_i | input | 2 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| err_pend_o | output | 1 | Error pending, interrupt source |

## Verification
The bench first sends a second, different error while the first is still pending. A design that overwrote the snapshot would report the later address or command.

It also tests the W1C bit both ways. A design that cleared on a written zero, or that wiped the captured fields along with the flag, would lose the pending state or the byte enables.

A clearing write is placed in the same cycle as a new error. A design that gave the error priority would leave the flag set and hold the new address.

Finally, the bench sends errors with the enable off and writes to the read-only selects. A design that leaked through either path would show a changed address or a raised flag.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;
  localparam int unsigned CSR_W   = 32;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_PND = 8;
  localparam int unsigned BIT_MAB = 9;
  localparam int unsigned BIT_RTY = 10;
  localparam int unsigned TOP_LSB = 24;

  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/err_cap_ctrl.sv
module err_cap_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic rty_exp_i,
  input  logic mabort_i,
  input  logic csr_we_i,
  input  logic wr_en_i,
  input  logic wr_clr_i,
  output logic en_o,
  output logic pend_o,
  output logic rty_o,
  output logic mab_o,
  output logic capture_o
);
  logic en_q, pend_q, rty_q, mab_q;

  // capture is gated by registered state, so a same-cycle clear drops the error
  assign capture_o = err_i & en_q & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      rty_q  <= 1'b0;
      mab_q  <= 1'b0;
    end else begin
      if (csr_we_i) en_q <= wr_en_i;
      if (capture_o) begin
        pend_q <= 1'b1;
        rty_q  <= rty_exp_i;
        mab_q  <= mabort_i;
      end else if (csr_we_i && wr_clr_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign rty_o  = rty_q;
  assign mab_o  = mab_q;

  AST_CAPT_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && en_q && !pend_q) |=> pend_q); // R2
  AST_NO_CAPT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !pend_q) |=> !pend_q); // R3
  AST_FLAGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> ($stable(rty_q) && $stable(mab_q))); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && csr_we_i && wr_clr_i) |=> !pend_q); // R10
  AST_ZERO_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !(csr_we_i && wr_clr_i)) |=> pend_q); // R6
endmodule

// File: rtl/err_cap_store.sv
module err_cap_store #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= d_i;
  end

  assign q_o = q;

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q == $past(d_i))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q)); // R4
endmodule

// File: rtl/err_cap_rdmux.sv
module err_cap_rdmux
  import err_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TOP_W  = 8
) (
  input  logic [1:0]        sel_i,
  input  logic [TOP_W-1:0]  top_i,
  input  logic              rty_i,
  input  logic              mab_i,
  input  logic              pend_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CSR_W-1:0]  rdata_o
);
  logic [CSR_W-1:0] csr;

  always_comb begin
    csr = '0;
    csr[CSR_W-1:TOP_LSB] = top_i;
    csr[BIT_RTY] = rty_i;
    csr[BIT_MAB] = mab_i;
    csr[BIT_PND] = pend_i;
    csr[BIT_EN]  = en_i;
  end

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_CSR:  rdata_o = csr;
      SEL_ADDR: rdata_o = CSR_W'(addr_i);
      SEL_DATA: rdata_o = CSR_W'(data_i);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import err_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4,
  parameter int unsigned CMD_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_i,
  input  logic              rty_exp_i,
  input  logic              mabort_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              err_pend_o
);
  localparam int unsigned TOP_W = BE_W + CMD_W;

  logic csr_we, en, pend, rty, mab, capture;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TOP_W-1:0]  top_q;

  assign csr_we = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_CSR);

  err_cap_ctrl u_ctrl (
    .clk_i, .rst_ni, .err_i, .rty_exp_i, .mabort_i,
    .csr_we_i (csr_we),
    .wr_en_i  (reg_wdata_i[BIT_EN]),
    .wr_clr_i (reg_wdata_i[BIT_PND]),
    .en_o     (en),
    .pend_o   (pend),
    .rty_o    (rty),
    .mab_o    (mab),
    .capture_o(capture)
  );

  err_cap_store #(.W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .load_i(capture), .d_i(addr_i), .q_o(addr_q));
  err_cap_store #(.W(DATA_W)) u_data (
    .clk_i, .rst_ni, .load_i(capture), .d_i(data_i), .q_o(data_q));
  err_cap_store #(.W(TOP_W)) u_top (
    .clk_i, .rst_ni, .load_i(capture), .d_i({be_i, cmd_i}), .q_o(top_q));

  err_cap_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_W(TOP_W)) u_rd (
    .sel_i(reg_sel_i), .top_i(top_q), .rty_i(rty), .mab_i(mab),
    .pend_i(pend), .en_i(en), .addr_i(addr_q), .data_i(data_q),
    .rdata_o(reg_rdata_o)
  );

  assign err_pend_o = pend;

  AST_PEND_MATCHES_CSR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_e'(reg_sel_i) == SEL_CSR) |-> (err_pend_o == reg_rdata_o[BIT_PND])); // R8
  AST_ADDR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |=> $stable(addr_q)); // R4
endmodule

// File: tb/bus_err_capture_test.sv
module bus_err_capture_test;
  logic        clk = 0, rst_n = 0;
  logic        err = 0, rty = 0, mab = 0;
  logic [31:0] addr = 0, data = 0, wdata = 0;
  logic [3:0]  be = 0, cmd = 0;
  logic [1:0]  sel = 0;
  logic        we = 0;
  logic [31:0] rdata;
  logic        pend;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  bus_err_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .rty_exp_i(rty), .mabort_i(mab),
    .addr_i(addr), .data_i(data), .be_i(be), .cmd_i(cmd),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .err_pend_o(pend)
  );

  typedef struct packed {
    logic [31:0] a; logic [31:0] d; logic [3:0] b; logic [3:0] c; logic r; logic m;
  } vec_t;
  localparam vec_t VEC [4] = '{
    '{32'h1000_0004, 32'hDEAD_BEEF, 4'hF, 4'h7, 1'b1, 1'b0},
    '{32'hFFFF_FFFC, 32'h0000_0001, 4'h1, 4'h6, 1'b0, 1'b1},
    '{32'h8000_0000, 32'hA5A5_5A5A, 4'hC, 4'hB, 1'b1, 1'b1},
    '{32'h0000_0010, 32'h1234_5678, 4'h3, 4'h2, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    sel = s; #1; v = rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk); sel = s; wdata = v; we = 1;
    @(negedge clk); we = 0; wdata = 0; sel = 0;
  endtask

  task automatic fire(input vec_t v);
    @(negedge clk); addr = v.a; data = v.d; be = v.b; cmd = v.c; rty = v.r; mab = v.m; err = 1;
    @(negedge clk); err = 0; rty = 0; mab = 0;
  endtask

  function automatic logic [31:0] csr_of(input vec_t v, input logic p, input logic e);
    return {v.b, v.c, 13'b0, v.r, v.m, p, 7'b0, e};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    vec_t other;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 csr", v, 0);
    rd(1, v); chk("R1 addr", v, 0);
    rd(2, v); chk("R1 data", v, 0);
    chk("R1 pend", {31'b0, pend}, 0);

    // R3 disabled: no capture
    fire(VEC[0]);
    rd(0, v); chk("R3 csr", v, 0);
    rd(1, v); chk("R3 addr", v, 0);

    // R7 enable readback
    wr(0, 32'h0000_0001);
    rd(0, v); chk("R7 en", v, 32'h1);

    for (int i = 0; i < 4; i++) begin
      fire(VEC[i]);
      rd(0, v); chk("R2 csr", v, csr_of(VEC[i], 1, 1));
      rd(1, v); chk("R2 addr", v, VEC[i].a);
      rd(2, v); chk("R2 data", v, VEC[i].d);
      chk("R8 pend", {31'b0, pend}, 1);
      other = VEC[(i + 1) % 4];
      other.a = ~VEC[i].a; other.r = ~VEC[i].r; other.m = ~VEC[i].m;
      fire(other);
      rd(0, v); chk("R4 csr", v, csr_of(VEC[i], 1, 1));
      rd(1, v); chk("R4 addr", v, VEC[i].a);
      wr(0, 32'h0000_0101);
      rd(0, v); chk("R5 csr", v, csr_of(VEC[i], 0, 1));
      chk("R8 pend clr", {31'b0, pend}, 0);
    end

    // R6 writing 0 to bit 8 and junk to RO bits
    fire(VEC[0]);
    wr(0, 32'hFFFF_FE01);
    rd(0, v); chk("R6 csr", v, csr_of(VEC[0], 1, 1));

    // R9 writes to other selects ignored; select 3 reads zero
    wr(1, 32'h5555_5555);
    wr(2, 32'h6666_6666);
    wr(3, 32'h7777_7777);
    rd(1, v); chk("R9 addr", v, VEC[0].a);
    rd(2, v); chk("R9 data", v, VEC[0].d);
    rd(3, v); chk("R9 sel3", v, 0);

    // R10 clear and error in the same cycle
    @(negedge clk);
    sel = 0; wdata = 32'h0000_0101; we = 1;
    addr = VEC[2].a; data = VEC[2].d; be = VEC[2].b; cmd = VEC[2].c; err = 1;
    @(negedge clk); we = 0; err = 0; wdata = 0;
    rd(0, v); chk("R10 csr", v, csr_of(VEC[0], 0, 1));
    rd(1, v); chk("R10 addr", v, VEC[0].a);
    fire(VEC[2]);
    rd(1, v); chk("R10 recapture", v, VEC[2].a);

    // R7 disable again, R3 no capture after clear
    wr(0, 32'h0000_0100);
    fire(VEC[3]);
    rd(0, v); chk("R3 off csr", v, csr_of(VEC[2], 0, 0));
    rd(1, v); chk("R3 off addr", v, VEC[2].a);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(0, v); chk("R1 rerst csr", v, 0);
    rd(1, v); chk("R1 rerst addr", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule